// File: doc/BRIEF.md
# Real-Time Clock Periodic Interrupt Generator

This block creates the periodic interrupt of a real-time clock. It works on a fast system clock. The timebase gives it a sub-second strobe, and the time counters give it rollover strobes for seconds, minutes, hours and months. A 3-bit cycle-select field picks one of six periods. Two of them are free-running square waves at 2 Hz and 1 Hz. The other four are latched levels, set once per second, minute, hour or month.

The block keeps one periodic flag. In square-wave mode the flag follows the waveform. In latched mode it stays set until software writes a 0 to it through a one-bit register port. The flag, ORed with the alarm requests, drives an active-low interrupt request that goes out to the shared pad.

Within each second the block tracks a sub-second phase of PHASE_W bits. The phase counts sub-ticks, and a second rollover forces it back to zero. Both square waves therefore go active at the moment the second counter advances.

Top module: `rtc_periodic_irq`

## Requirements
- R1: While reset is asserted, and after it is released with cycle-select at 000, ct_flag is 0 and irq_n is 1.
- R2: Cycle-select 000 or 111 disables the function. ct_flag reads 0 from the cycle after such a value is applied, and the rollover strobes and flag writes have no effect.
- R3: Cycle-select 001 gives a 2 Hz square wave. ct_flag is 1 exactly when phase bit PHASE_W-2 is 0; with PHASE_W=2 that means phases 0 and 2 of the four quarter-second phases.
- R4: Cycle-select 010 gives a 1 Hz square wave. ct_flag is 1 exactly when the phase MSB is 0, which is the first half of each second.
- R5: The phase counts up by one on each sub_tick and wraps at 2**PHASE_W. A sec_roll forces the phase to 0 and takes priority over sub_tick.
- R6: In latched mode, cycle-select 011, 100, 101 or 110 sets ct_flag on sec_roll, min_roll, hour_roll or mon_roll respectively. The other three strobes do not set it.
- R7: In latched mode ct_flag holds its value until flag_wr is asserted with flag_wdata 0. A write of 1 leaves the flag unchanged.
- R8: In latched mode, if the selected strobe and a clearing write arrive in the same cycle, the flag ends up set.
- R9: In either square-wave mode, flag writes have no effect. ct_flag keeps following the waveform.
- R10: irq_n is 0 whenever ct_flag is 1 or any bit of alarm_req is 1, and 1 otherwise. It responds in the same cycle as those signals, with no added register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cyc_sel | input | 3 | Period and mode select |
| sub_tick | input | 1 | One-cycle strobe, 2**PHASE_W per second |
| sec_roll | input | 1 | Second-advance strobe |
| min_roll | input | 1 | Minute rollover strobe |
| hour_roll | input | 1 | Hour rollover strobe |
| mon_roll | input | 1 | Month rollover strobe |
| flag_wr | input | 1 | Write strobe for the periodic flag |
| flag_wdata | input | 1 | Write data; 0 clears the flag |
| alarm_req | input | N_ALARM | Active-high alarm requests that share the interrupt line |
| ct_flag | output | 1 | Periodic flag, readable by software |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A strobe or write that is present at a rising edge takes effect on the phase and on ct_flag at that edge. The result can therefore be seen one cycle later. irq_n follows ct_flag and alarm_req in the same cycle.

The bench changes every input just after a falling edge. It predicts the state that the next rising edge will produce, then compares both outputs at the following falling edge, so each comparison lands exactly one register stage after its stimulus.

After reset is released, the bench waits out the two-cycle reset synchronizer before it drives any strobe. The sweep then covers all eight select values, first with directed sequences and then with a long pseudo-random stream of strobes, writes and alarms.

// File: rtl/rtc_pirq_pkg.sv
package rtc_pirq_pkg;

  localparam int unsigned SEL_W = 3;

  typedef enum logic [1:0] {
    PI_OFF   = 2'd0,
    PI_PULSE = 2'd1,
    PI_LEVEL = 2'd2
  } pi_kind_e;

  // src: 0 second, 1 minute, 2 hour, 3 month
  typedef struct packed {
    pi_kind_e   kind;
    logic       fast;
    logic [1:0] src;
  } pi_cfg_t;

endpackage

// File: rtl/rtc_pirq_decode.sv
module rtc_pirq_decode
  import rtc_pirq_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  output pi_cfg_t          cfg
);

  always_comb begin
    cfg.kind = PI_OFF;
    cfg.fast = 1'b0;
    cfg.src  = 2'd0;
    unique case (sel)
      3'b001: begin cfg.kind = PI_PULSE; cfg.fast = 1'b1; end
      3'b010: begin cfg.kind = PI_PULSE; cfg.fast = 1'b0; end
      3'b011: begin cfg.kind = PI_LEVEL; cfg.src = 2'd0; end
      3'b100: begin cfg.kind = PI_LEVEL; cfg.src = 2'd1; end
      3'b101: begin cfg.kind = PI_LEVEL; cfg.src = 2'd2; end
      3'b110: begin cfg.kind = PI_LEVEL; cfg.src = 2'd3; end
      default: begin cfg.kind = PI_OFF; end
    endcase
  end

endmodule

// File: rtl/rtc_pirq_phase.sv
module rtc_pirq_phase #(
  parameter int unsigned PHASE_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sub_tick,
  input  logic               sec_roll,
  output logic [PHASE_W-1:0] phase_d,
  output logic [PHASE_W-1:0] phase_q
);

  logic ph_en;

  always_comb begin
    ph_en   = sub_tick | sec_roll;
    phase_d = phase_q;
    if (sec_roll)      phase_d = '0;
    else if (sub_tick) phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     phase_q <= '0;
    else if (ph_en) phase_q <= phase_d;
  end

  // R5: second advance realigns the phase
  a_r5_sec_realign: assert property (@(posedge clk) disable iff (!rst_n)
    sec_roll |=> (phase_q == '0));

  // R5: sub-tick steps the phase by one
  a_r5_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_tick && !sec_roll) |=> (phase_q == PHASE_W'($past(phase_q) + 1'b1)));

endmodule

// File: rtl/rtc_pirq_flag.sv
module rtc_pirq_flag
  import rtc_pirq_pkg::*;
#(
  parameter int unsigned PHASE_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  pi_cfg_t            cfg,
  input  logic [PHASE_W-1:0] phase_nxt,
  input  logic [3:0]         roll_vec,
  input  logic               wr_en,
  input  logic               wr_data,
  output logic               flag_q
);

  logic set_hit;
  logic clr_hit;
  logic wave;
  logic flag_d;

  always_comb begin
    set_hit = roll_vec[cfg.src];
    clr_hit = wr_en & ~wr_data;
    wave    = cfg.fast ? ~phase_nxt[PHASE_W-2] : ~phase_nxt[PHASE_W-1];
    unique case (cfg.kind)
      PI_PULSE: flag_d = wave;
      PI_LEVEL: flag_d = set_hit | (flag_q & ~clr_hit);
      default:  flag_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  // R2: disabled selection forces the flag low next cycle
  a_r2_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.kind == PI_OFF) |=> !flag_q);

  // R7: latched flag holds without set or clearing write
  a_r7_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.kind == PI_LEVEL && !roll_vec[cfg.src] && !(wr_en && !wr_data))
      |=> $stable(flag_q));

  // R8: a set strobe wins over a clear in the same cycle
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.kind == PI_LEVEL && roll_vec[cfg.src]) |=> flag_q);

endmodule

// File: rtl/rtc_periodic_irq.sv
module rtc_periodic_irq
  import rtc_pirq_pkg::*;
#(
  parameter int unsigned PHASE_W = 2,
  parameter int unsigned N_ALARM = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SEL_W-1:0]   cyc_sel,
  input  logic               sub_tick,
  input  logic               sec_roll,
  input  logic               min_roll,
  input  logic               hour_roll,
  input  logic               mon_roll,
  input  logic               flag_wr,
  input  logic               flag_wdata,
  input  logic [N_ALARM-1:0] alarm_req,
  output logic               ct_flag,
  output logic               irq_n
);

  logic [1:0]         rs_q;
  logic               rst_core_n;
  pi_cfg_t            cfg;
  logic [PHASE_W-1:0] phase_d;
  logic [PHASE_W-1:0] phase_q;
  logic [3:0]         roll_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  assign roll_vec = {mon_roll, hour_roll, min_roll, sec_roll};

  rtc_pirq_decode u_decode (
    .sel (cyc_sel),
    .cfg (cfg)
  );

  rtc_pirq_phase #(.PHASE_W(PHASE_W)) u_phase (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .sub_tick (sub_tick),
    .sec_roll (sec_roll),
    .phase_d  (phase_d),
    .phase_q  (phase_q)
  );

  rtc_pirq_flag #(.PHASE_W(PHASE_W)) u_flag (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .cfg       (cfg),
    .phase_nxt (phase_d),
    .roll_vec  (roll_vec),
    .wr_en     (flag_wr),
    .wr_data   (flag_wdata),
    .flag_q    (ct_flag)
  );

  assign irq_n = ~(ct_flag | (|alarm_req));

  // R4: in 1 Hz square-wave mode the flag tracks the phase MSB
  a_r4_onehz_track: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cyc_sel == 3'b010) |=> (ct_flag == ~phase_q[PHASE_W-1]));

endmodule

// File: tb/rtc_periodic_irq_tb_top.sv
module rtc_periodic_irq_tb_top;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned PHASE_W    = 2;
  localparam int unsigned N_ALARM    = 2;

  logic               clk;
  logic               rst_n;
  logic [2:0]         cyc_sel;
  logic               sub_tick, sec_roll, min_roll, hour_roll, mon_roll;
  logic               flag_wr, flag_wdata;
  logic [N_ALARM-1:0] alarm_req;
  logic               ct_flag, irq_n;

  int unsigned n_vec;
  int unsigned n_bad;
  logic [PHASE_W-1:0] m_phase;
  logic               m_flag;
  logic [15:0]        lf;

  rtc_periodic_irq #(.PHASE_W(PHASE_W), .N_ALARM(N_ALARM)) dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_sel(cyc_sel), .sub_tick(sub_tick),
    .sec_roll(sec_roll), .min_roll(min_roll), .hour_roll(hour_roll),
    .mon_roll(mon_roll), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
    .alarm_req(alarm_req), .ct_flag(ct_flag), .irq_n(irq_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic act, logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  task automatic idle_inputs();
    sub_tick = 0; sec_roll = 0; min_roll = 0; hour_roll = 0; mon_roll = 0;
    flag_wr = 0; flag_wdata = 0; alarm_req = '0;
  endtask

  // Predict state after next rising edge, then compare at the falling edge.
  task automatic step(string tag);
    logic [PHASE_W-1:0] ph;
    logic               f;
    logic               set_s;
    ph = sec_roll ? '0 : (sub_tick ? PHASE_W'(m_phase + 1'b1) : m_phase);
    case (cyc_sel)
      3'd3: set_s = sec_roll;
      3'd4: set_s = min_roll;
      3'd5: set_s = hour_roll;
      3'd6: set_s = mon_roll;
      default: set_s = 1'b0;
    endcase
    case (cyc_sel)
      3'd1: f = (ph[PHASE_W-2] == 1'b0);
      3'd2: f = (ph[PHASE_W-1] == 1'b0);
      3'd3, 3'd4, 3'd5, 3'd6: f = set_s | (m_flag & ~(flag_wr & ~flag_wdata));
      default: f = 1'b0;
    endcase
    m_phase = ph;
    m_flag  = f;
    @(negedge clk);
    check(tag, ct_flag, m_flag);
    check("R10", irq_n, ~(m_flag | (|alarm_req)));
  endtask

  function automatic string sel_tag(logic [2:0] s);
    case (s)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3, 3'd4, 3'd5, 3'd6: return "R6";
      default: return "R2";
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    n_vec = 0; n_bad = 0;
    m_phase = '0; m_flag = 1'b0; lf = 16'hACE1;
    rst_n = 1'b0; cyc_sel = 3'd0;
    idle_inputs();
    repeat (3) @(negedge clk);
    check("R1", ct_flag, 1'b0);
    check("R1", irq_n, 1'b1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", ct_flag, 1'b0);
    check("R1", irq_n, 1'b1);

    // R5: sub-ticks walk the phase, sec_roll realigns it (1 Hz view)
    cyc_sel = 3'd2;
    step("R4");
    sub_tick = 1; step("R5"); step("R5"); step("R5");
    sec_roll = 1; step("R5");
    sec_roll = 1; sub_tick = 1; step("R5");
    sec_roll = 0; step("R5"); sub_tick = 0;

    // R9: clearing writes ignored in pulse mode
    cyc_sel = 3'd1;
    step("R3");
    flag_wr = 1; flag_wdata = 0; step("R9"); step("R9");
    flag_wr = 0; sub_tick = 1; step("R3"); step("R3"); sub_tick = 0;

    // R6/R7/R8: latched minute mode
    cyc_sel = 3'd4;
    flag_wr = 1; flag_wdata = 0; step("R7"); flag_wr = 0;
    sec_roll = 1; hour_roll = 1; mon_roll = 1; step("R6");
    sec_roll = 0; hour_roll = 0; mon_roll = 0;
    min_roll = 1; step("R6"); min_roll = 0;
    step("R7"); step("R7");
    flag_wr = 1; flag_wdata = 1; step("R7");
    flag_wdata = 0; step("R7"); flag_wr = 0;
    min_roll = 1; flag_wr = 1; flag_wdata = 0; step("R8");
    min_roll = 0; flag_wr = 0; step("R8");

    // R2: disable while set, strobes ignored
    cyc_sel = 3'd0; step("R2");
    sec_roll = 1; min_roll = 1; hour_roll = 1; mon_roll = 1; step("R2");
    cyc_sel = 3'd7; step("R2");
    idle_inputs();

    // R10: alarms drive irq_n with flag clear
    alarm_req = 2'b01; step("R10");
    alarm_req = 2'b10; step("R10");
    alarm_req = 2'b00; step("R10");

    // Sweep all selections with a pseudo-random strobe stream
    for (int pass = 0; pass < 2; pass++) begin
      for (int s = 0; s < 8; s++) begin
        cyc_sel = 3'(s);
        for (int k = 0; k < 400; k++) begin
          lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
          sub_tick   = lf[0];
          sec_roll   = lf[1] & lf[2] & lf[3];
          min_roll   = lf[4] & lf[5];
          hour_roll  = lf[6] & lf[7];
          mon_roll   = lf[8] & lf[9];
          flag_wr    = lf[10] & lf[11];
          flag_wdata = lf[12];
          alarm_req  = {lf[13] & lf[14] & lf[15], lf[15] & lf[14] & lf[2]};
          step(sel_tag(cyc_sel));
        end
      end
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule